// File: doc/BRIEF.md
# Bit-Serial Modular Adder, Subtractor and Doubler

This unit forms `(a + b) mod n`, `(a - b) mod n` or `(2a) mod n` one bit per clock. Operands are shifted through a single full adder/subtractor cell, least significant bit first. The operation runs in one or two passes of `W` cycles each. The first pass produces the raw sum or difference. A second pass either removes the modulus from a sum that reached it, or restores the modulus to a difference that went negative. That second pass runs only when the outcome of the first pass calls for it. The time to completion therefore depends on the data, and is either `W` or `2W` cycles.

The caller loads the operands with a one-cycle `start` and waits for the one-cycle `done`. It then reads `result`, which stays put until the next accepted `start`. A second arithmetic cell runs during the first pass only. It serially compares the raw sum against `n`, so that the decision for an addition is ready when the last bit of the first pass is processed.

Top module: `modas_unit`

## Requirements
- R1: After synchronous reset, `done` is 0 and `result` is 0, and the unit is idle.
- R2: For operands `a`, `b` in `[0, n)`, the op code 2'b00 returns `(a + b) mod n`.
- R3: For operands `a`, `b` in `[0, n)`, the op code 2'b01 returns `(a - b) mod n`.
- R4: The op code 2'b10 returns `(2a) mod n`. The `b` input has no effect on the result or on the latency.
- R5: The op code 2'b11 behaves exactly as an addition (2'b00).
- R6: Each pass takes exactly `W` clocks. Counting the clocks after the edge that accepts `start`, `done` rises after `W` clocks when no correction runs and after `2W` clocks when it does.
- R7: For an addition or a doubling, the correction pass runs if and only if the raw sum is at least `n`. This includes a sum exactly equal to `n`, which gives 0, and a sum that overflows `W` bits.
- R8: For a subtraction, the correction pass runs if and only if `a < b`. Equal operands give 0 with no correction.
- R9: `done` is high for exactly one clock. `result` holds its value from that pulse until the next accepted `start`.
- R10: A `start` that arrives while an operation is in progress is ignored. The running operation finishes with its own result and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept operands and begin when idle |
| op | input | 2 | 00 add, 01 subtract, 10 double, 11 add |
| a | input | W | First operand |
| b | input | W | Second operand (unused for double) |
| n | input | W | Modulus |
| result | output | W | Modular result, valid from `done` onward |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are those in which the correction decision sits on a knife edge. Examples are a sum exactly equal to `n`, a sum whose carry leaves the `W`-bit field, and a difference of equal operands that must not trigger a correction. In each of these a wrong carry, borrow or comparison bit changes the result and the latency by a whole pass. The stimulus table sets up each of these directly, with values chosen by hand, and also includes a modulus near `2^W`.

The bench then measures both the value and the cycle count of every operation, so that a wrongly taken or skipped correction is caught even when the final value would happen to agree. A `start` pulse issued in the middle of a pass covers the ignored-request case.

// File: rtl/modas_pkg.sv
package modas_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_DBL     = 2'b10,
        OP_ADD_ALT = 2'b11
    } modas_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FIRST = 2'b01,
        ST_FIX   = 2'b10
    } modas_state_e;

    typedef struct packed {
        logic z;    // output bit
        logic cy;   // carry (add) or borrow (subtract)
    } bit_res_t;

    function automatic bit_res_t serial_step(input logic x, input logic y,
                                             input logic cin, input logic do_sub);
        bit_res_t r;
        r.z = x ^ y ^ cin;
        if (do_sub)
            r.cy = (~x & y) | (~x & cin) | (y & cin);
        else
            r.cy = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

    function automatic int cnt_width(input int w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/modas_bitcell.sv
module modas_bitcell
    import modas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic do_sub,
    input  logic x,
    input  logic y,
    output logic z,
    output logic cy_next
);
    logic     cy_q;
    bit_res_t r;

    always_comb begin
        r       = serial_step(x, y, cy_q, do_sub);
        z       = r.z;
        cy_next = r.cy;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cy_q <= 1'b0;
        else if (clr)
            cy_q <= 1'b0;
        else if (en)
            cy_q <= cy_next;
    end

endmodule

// File: rtl/modas_seq.sv
module modas_seq
    import modas_pkg::*;
#(
    parameter int W = 160
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     need_fix,
    output modas_state_e             st,
    output logic [cnt_width(W)-1:0]  cnt,
    output logic                     accept,
    output logic                     enter_fix,
    output logic                     done
);
    localparam int CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic last;

    always_comb begin
        last      = (cnt == LAST);
        accept    = (st == ST_IDLE) && start;
        enter_fix = (st == ST_FIRST) && last && need_fix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) st <= ST_FIRST;
                end
                ST_FIRST: begin
                    if (last) begin
                        cnt <= '0;
                        if (need_fix) begin
                            st <= ST_FIX;
                        end else begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FIX: begin
                    if (last) begin
                        cnt  <= '0;
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6: the correcting pass is entered only straight after the final bit of the first pass
    a_r6_fix_follows_first: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FIX && $past(st) != ST_FIX) |-> ($past(st) == ST_FIRST && $past(cnt) == LAST));

    // R6: the bit counter never passes the last bit position
    a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (cnt <= LAST));

    // R10: a start during a pass does not restart the count
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FIRST && !last && start) |=> (st == ST_FIRST && cnt == $past(cnt) + 1'b1));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/modas_unit.sv
module modas_unit
    import modas_pkg::*;
#(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic [W-1:0] result,
    output logic         done
);
    localparam int CW = cnt_width(W);

    modas_state_e  st;
    logic [CW-1:0] cnt;
    logic          accept, enter_fix, need_fix;

    logic [W-1:0]  a_sr, b_sr, n_sr, r_sr;
    logic          mode_sub;

    logic          step, in_first;
    logic          m_x, m_y, m_sub, m_z, m_cy;
    logic          t_z, t_cy;

    always_comb begin
        step     = (st != ST_IDLE);
        in_first = (st == ST_FIRST);
        m_x      = in_first ? a_sr[0] : r_sr[0];
        m_y      = in_first ? b_sr[0] : n_sr[0];
        m_sub    = in_first ? mode_sub : ~mode_sub;
        // addition: fix when carry out, or when the low bits do not borrow against n
        need_fix = mode_sub ? m_cy : (m_cy | ~t_cy);
        result   = r_sr;
    end

    modas_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .need_fix  (need_fix),
        .st        (st),
        .cnt       (cnt),
        .accept    (accept),
        .enter_fix (enter_fix),
        .done      (done)
    );

    // main serial cell: raw op in the first pass, correction in the second
    modas_bitcell u_main (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept | enter_fix),
        .en      (step),
        .do_sub  (m_sub),
        .x       (m_x),
        .y       (m_y),
        .z       (m_z),
        .cy_next (m_cy)
    );

    // trial cell: serial compare of the raw sum against n during the first pass
    modas_bitcell u_trial (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .en      (in_first),
        .do_sub  (1'b1),
        .x       (m_z),
        .y       (n_sr[0]),
        .z       (t_z),
        .cy_next (t_cy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sr     <= '0;
            b_sr     <= '0;
            n_sr     <= '0;
            r_sr     <= '0;
            mode_sub <= 1'b0;
        end else if (accept) begin
            a_sr     <= a;
            b_sr     <= (modas_op_e'(op) == OP_DBL) ? a : b;
            n_sr     <= n;
            r_sr     <= '0;
            mode_sub <= (modas_op_e'(op) == OP_SUB);
        end else if (step) begin
            if (in_first) begin
                a_sr <= {1'b0, a_sr[W-1:1]};
                b_sr <= {1'b0, b_sr[W-1:1]};
            end
            n_sr <= {n_sr[0], n_sr[W-1:1]};
            r_sr <= {m_z, r_sr[W-1:1]};
        end
    end

    // R9: result holds while idle and no new start arrives
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> $stable(result));

    // R6: done only follows a pass
    a_r6_done_after_pass: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st) == ST_FIRST || $past(st) == ST_FIX));

    // R8: a subtraction enters correction only on a borrow
    a_r8_sub_fix_on_borrow: assert property (@(posedge clk) disable iff (rst)
        (enter_fix && mode_sub) |-> m_cy);

endmodule

// File: tb/sim_modas_unit.sv
module sim_modas_unit;
    localparam int W = 16;
    localparam int NV = 15;
    localparam int MAXWAIT = 4 * W + 10;

    // {op[1:0], a[15:0], b[15:0], n[15:0]}
    localparam logic [49:0] VEC [NV] = '{
        {2'b00, 16'd300,   16'd200,   16'd1000},
        {2'b00, 16'd600,   16'd400,   16'd1000},
        {2'b00, 16'd999,   16'd999,   16'd1000},
        {2'b00, 16'd0,     16'd0,     16'd1000},
        {2'b00, 16'd500,   16'd500,   16'd1000},
        {2'b01, 16'd700,   16'd200,   16'd1000},
        {2'b01, 16'd200,   16'd700,   16'd1000},
        {2'b01, 16'd5,     16'd5,     16'd1000},
        {2'b01, 16'd0,     16'd999,   16'd1000},
        {2'b10, 16'd600,   16'd123,   16'd1000},
        {2'b10, 16'd500,   16'd777,   16'd1000},
        {2'b10, 16'd0,     16'd999,   16'd1000},
        {2'b11, 16'd450,   16'd551,   16'd1000},
        {2'b00, 16'd65520, 16'd65520, 16'd65521},
        {2'b01, 16'd0,     16'd1,     16'd65521}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   op;
    logic [W-1:0] a, b, n;
    logic [W-1:0] result;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    modas_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .a(a), .b(b), .n(n), .result(result), .done(done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_op(input logic [1:0] o, input int ia, input int ib, input int in_,
                             output int er, output int el);
        int s;
        bit fix;
        if (o == 2'b01) begin
            fix = (ia < ib);
            er  = fix ? ia - ib + in_ : ia - ib;
        end else begin
            s   = (o == 2'b10) ? 2 * ia : ia + ib;
            fix = (s >= in_);
            er  = fix ? s - in_ : s;
        end
        el = fix ? 2 * W : W;
    endtask

    // issues one operation; optional disturbing start in mid pass
    task automatic run_op(input logic [1:0] o, input int ia, input int ib, input int in_,
                          input string req, input bit disturb);
        int er, el, cyc;
        expect_op(o, ia, ib, in_, er, el);
        @(negedge clk);
        op = o; a = W'(ia); b = W'(ib); n = W'(in_); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < MAXWAIT) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (disturb && cyc == 3) begin
                op = 2'b01; a = W'(1); b = W'(2); n = W'(7); start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check({req, " result"}, result, er);
        check({req, " latency R6"}, cyc, el);
        @(negedge clk);
        check({req, " done pulse R9"}, done, 0);
        check({req, " hold R9"}, result, er);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op = 2'b00; a = '0; b = '0; n = W'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 result", result, 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] vo;
            string tag;
            vo = VEC[i][49:48];
            case (vo)
                2'b00:   tag = "R2 R7 add";
                2'b01:   tag = "R3 R8 sub";
                2'b10:   tag = "R4 R7 double";
                default: tag = "R5 alt add";
            endcase
            run_op(vo, int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]), tag, 1'b0);
        end

        // random operands within [0, n)
        for (int i = 0; i < 40; i++) begin
            int rn, ra, rb;
            logic [1:0] ro;
            rn = 1 + int'($urandom_range(65534));
            ra = int'($urandom_range(rn - 1));
            rb = int'($urandom_range(rn - 1));
            ro = 2'($urandom_range(3));
            run_op(ro, ra, rb, rn, "R2 R3 R4 R5 random", 1'b0);
        end

        // R4: b does not affect a doubling
        run_op(2'b10, 333, 0, 1000, "R4 b ignored", 1'b0);
        run_op(2'b10, 333, 65535, 1000, "R4 b ignored", 1'b0);

        // R10: start during a pass is ignored
        run_op(2'b00, 800, 300, 1000, "R10 busy start", 1'b1);
        run_op(2'b01, 10, 20, 1000, "R10 busy start", 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule